// File: doc/BRIEF.md
# Banked Integer Register File

This block is the integer register storage of a 64-bit processor core. It holds thirty-one 64-bit general-purpose registers, serves two combinational read ports and one write port, and can access each register either at full width or as its low 32-bit half. The all-ones register index is a zero sink. Reads of it return zero, and writes to it are thrown away. The exception is an explicit request for the stack pointer on read port A or on the write port.

Four stack pointers are kept apart from the general registers, one per privilege level 0 to 3. A select bit picks either the level-0 stack pointer or the stack pointer of the current level. At level 0 the pick is always the level-0 pointer. When checking is enabled, reading a stack pointer whose low four bits are not zero raises an alignment fault. A dedicated link input writes a return address into register 30 in the same cycle as an ordinary write.

All reads are combinational, and a read sees any write made to the same location in the same cycle. Writes commit on the rising clock edge. Register and stack-pointer contents are undefined after reset, so software must write them before relying on them. The ports carry no handshake: every access completes in the cycle it is presented, so back-pressure never arises.

Top module: `banked_int_rf`

## Requirements
- R1: Registers 0 to 30 each store a full 64-bit value written with `wr_narrow`=0, and return it on both read ports with the narrow flag low.
- R2: A read with its narrow flag high returns bits 31:0 of the register, with bits 63:32 of the output zero.
- R3: A write with `wr_narrow`=1 stores `wr_data[31:0]` and clears bits 63:32 of the destination.
- R4: Index 31 reads as zero on port B always, and on port A when `rd_a_use_sp`=0. A write to index 31 with `wr_use_sp`=0 changes no general register and no stack pointer.
- R5: Four stack pointers exist, one per level 0 to 3. A write to index 31 with `wr_use_sp`=1 updates only the active stack pointer and no general register.
- R6: The active stack pointer is that of `priv_lvl` when `sp_sel`=1 and `priv_lvl`≠0, and the level-0 pointer otherwise. Port A returns it for index 31 with `rd_a_use_sp`=1.
- R7: `sp_fault` is 1 exactly when `align_chk_en`=1, port A is reading the stack pointer, and bits 3:0 of the value read (after bypass) are not all zero.
- R8: `lnk_en`=1 writes `lnk_addr` in full into register 30. If the general write targets register 30 in the same cycle, the link value wins. A general write to any other register in that cycle still completes.
- R9: A read of a location being written in the same cycle returns the new value, after narrow zero-extension of the write. This holds for general registers, link writes and stack pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset (disables checks; contents undefined) |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| sp_sel | input | 1 | 1 = use current level's stack pointer, 0 = level 0's |
| align_chk_en | input | 1 | Enable stack-pointer alignment fault |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_narrow | input | 1 | Port A 32-bit form |
| rd_a_use_sp | input | 1 | Index 31 on port A means stack pointer |
| rd_a_data | output | 64 | Port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_narrow | input | 1 | Port B 32-bit form |
| rd_b_data | output | 64 | Port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_narrow | input | 1 | Write in 32-bit form, zero-extended |
| wr_use_sp | input | 1 | Index 31 on write means stack pointer |
| wr_data | input | 64 | Write data |
| lnk_en | input | 1 | Link write to register 30 |
| lnk_addr | input | 64 | Return address for link write |
| sp_fault | output | 1 | Stack-pointer alignment fault |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a link write and a general write. The bench drives both at once, once to register 30 and once to another register. It then judges that register 30 holds the link value while the other register holds the general data. The second pair is a write and a read of the same location. The bench presents them together and compares the combinational output, sampled mid-cycle before the commit edge, against the new value, including narrow zero-extension. For stack pointers it also checks the alignment fault on the bypassed value.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_XLEN  = 64;
  localparam int unsigned RF_NREG  = 31;
  localparam int unsigned RF_NLVL  = 4;
  localparam int unsigned RF_ALIGN = 4;
  localparam int unsigned RF_LINK  = 30;
endpackage

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREG    = 31,
  parameter int unsigned LNK_IDX = 30,
  localparam int unsigned IDXW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_val,
  input  logic            lnk_en,
  input  logic [XLEN-1:0] lnk_val,
  input  logic [IDXW-1:0] rd_a_idx,
  input  logic [IDXW-1:0] rd_b_idx,
  output logic [XLEN-1:0] rd_a_val,
  output logic [XLEN-1:0] rd_b_val
);
  localparam logic [IDXW-1:0] LNK = IDXW'(LNK_IDX);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (lnk_en && LNK == IDXW'(i))
        mem[i] <= lnk_val;
      else if (wr_en && wr_idx == IDXW'(i))
        mem[i] <= wr_val;
    end
  end

  function automatic logic [XLEN-1:0] look(input logic [IDXW-1:0] idx);
    logic [XLEN-1:0] r;
    r = '0;
    if (idx < IDXW'(NREG)) begin
      if (lnk_en && idx == LNK)       r = lnk_val;
      else if (wr_en && idx == wr_idx) r = wr_val;
      else                             r = mem[idx];
    end
    return r;
  endfunction

  always_comb rd_a_val = look(rd_a_idx);
  always_comb rd_b_val = look(rd_b_idx);

  a_r8_link_lands: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_en |=> mem[LNK] == $past(lnk_val));
  a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_idx == wr_idx && wr_idx < IDXW'(NREG) && !(lnk_en && wr_idx == LNK))
      |-> rd_a_val == wr_val);
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < IDXW'(NREG) && !(lnk_en && wr_idx == LNK))
      |=> mem[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NLVL = 4,
  localparam int unsigned LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLW-1:0] lvl,
  input  logic            sel,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_val,
  output logic [XLEN-1:0] sp_val
);
  logic [XLEN-1:0] bank [NLVL];
  logic [LVLW-1:0] act;

  always_comb act = (sel && lvl != '0) ? lvl : '0;

  always_ff @(posedge clk) begin
    if (wr_en) bank[act] <= wr_val;
  end

  always_comb sp_val = wr_en ? wr_val : bank[act];

  a_r5_sp_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank[$past(act)] == $past(wr_val));
  a_r6_lvl0_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0 && !wr_en) |-> sp_val == bank[0]);
endmodule

// File: rtl/rf_sp_align.sv
module rf_sp_align #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned ALIGN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic            sp_use,
  input  logic [XLEN-1:0] sp_val,
  output logic            fault
);
  always_comb fault = chk_en && sp_use && (sp_val[ALIGN-1:0] != '0);

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> !fault);
  a_r7_aligned_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_val[ALIGN-1:0] == '0) |-> !fault);
endmodule

// File: rtl/banked_int_rf.sv
module banked_int_rf #(
  parameter int unsigned XLEN  = rf_pkg::RF_XLEN,
  parameter int unsigned NREG  = rf_pkg::RF_NREG,
  parameter int unsigned NLVL  = rf_pkg::RF_NLVL,
  parameter int unsigned ALIGN = rf_pkg::RF_ALIGN,
  parameter int unsigned LINK  = rf_pkg::RF_LINK,
  localparam int unsigned IDXW = $clog2(NREG + 1),
  localparam int unsigned LVLW = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLW-1:0] priv_lvl,
  input  logic            sp_sel,
  input  logic            align_chk_en,
  input  logic [IDXW-1:0] rd_a_idx,
  input  logic            rd_a_narrow,
  input  logic            rd_a_use_sp,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IDXW-1:0] rd_b_idx,
  input  logic            rd_b_narrow,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_narrow,
  input  logic            wr_use_sp,
  input  logic [XLEN-1:0] wr_data,
  input  logic            lnk_en,
  input  logic [XLEN-1:0] lnk_addr,
  output logic            sp_fault
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [IDXW-1:0] ZR = IDXW'(NREG);

  logic [XLEN-1:0] wr_fmt, gpr_a, gpr_b, sp_val, a_raw;
  logic            sp_wr, gpr_wr, a_sp;

  always_comb begin
    wr_fmt = wr_narrow ? {{HALF{1'b0}}, wr_data[HALF-1:0]} : wr_data;
    sp_wr  = wr_en && wr_use_sp && wr_idx == ZR;
    gpr_wr = wr_en && !sp_wr;
    a_sp   = rd_a_use_sp && rd_a_idx == ZR;
  end

  rf_gpr_bank #(.XLEN(XLEN), .NREG(NREG), .LNK_IDX(LINK)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(gpr_wr), .wr_idx(wr_idx), .wr_val(wr_fmt),
    .lnk_en(lnk_en), .lnk_val(lnk_addr),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_val(gpr_a), .rd_b_val(gpr_b)
  );

  rf_sp_bank #(.XLEN(XLEN), .NLVL(NLVL)) u_sp (
    .clk(clk), .rst_n(rst_n), .lvl(priv_lvl), .sel(sp_sel),
    .wr_en(sp_wr), .wr_val(wr_fmt), .sp_val(sp_val)
  );

  rf_sp_align #(.XLEN(XLEN), .ALIGN(ALIGN)) u_align (
    .clk(clk), .rst_n(rst_n), .chk_en(align_chk_en),
    .sp_use(a_sp), .sp_val(sp_val), .fault(sp_fault)
  );

  always_comb begin
    a_raw     = a_sp ? sp_val : gpr_a;
    rd_a_data = rd_a_narrow ? {{HALF{1'b0}}, a_raw[HALF-1:0]} : a_raw;
    rd_b_data = rd_b_narrow ? {{HALF{1'b0}}, gpr_b[HALF-1:0]} : gpr_b;
  end

  a_r4_port_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == ZR) |-> rd_b_data == '0);
  a_r4_port_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == ZR && !rd_a_use_sp) |-> rd_a_data == '0);
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_narrow |-> rd_a_data[XLEN-1:HALF] == '0);
  a_r7_fault_only_sp: assert property (@(posedge clk) disable iff (!rst_n)
    !a_sp |-> !sp_fault);
endmodule

// File: tb/tb_banked_int_rf.sv
module tb_banked_int_rf;
  logic clk = 0, rst_n = 0;
  logic [1:0] priv_lvl = 0;
  logic sp_sel = 0, align_chk_en = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic rd_a_narrow = 0, rd_a_use_sp = 0, rd_b_narrow = 0;
  logic wr_en = 0, wr_narrow = 0, wr_use_sp = 0, lnk_en = 0;
  logic [63:0] wr_data = 0, lnk_addr = 0, rd_a_data, rd_b_data;
  logic sp_fault;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] eg [31];
  logic [63:0] es [4];

  always #10 clk = ~clk;

  banked_int_rf dut (.*);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] pat(int i);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ (64'(i) << 40);
  endfunction

  function automatic int act_lvl();
    return (sp_sel && priv_lvl != 0) ? int'(priv_lvl) : 0;
  endfunction

  function automatic logic [63:0] fmt(logic [63:0] d, logic n);
    return n ? {32'h0, d[31:0]} : d;
  endfunction

  // one write cycle; commits on the posedge, model updated after
  task automatic wr(int idx, logic n, logic usp, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_narrow = n; wr_use_sp = usp; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (usp && idx == 31) es[act_lvl()] = fmt(d, n);
    else if (idx < 31) eg[idx] = fmt(d, n);
  endtask

  task automatic rd(int ia, logic na, logic ua, int ib, logic nb);
    @(negedge clk);
    rd_a_idx = 5'(ia); rd_a_narrow = na; rd_a_use_sp = ua;
    rd_b_idx = 5'(ib); rd_b_narrow = nb;
    #5;
  endtask

  function automatic logic [63:0] exp_a(int ia, logic na, logic ua);
    logic [63:0] v;
    if (ia == 31) v = ua ? es[act_lvl()] : 64'h0;
    else v = eg[ia];
    return fmt(v, na);
  endfunction

  function automatic logic [63:0] exp_b(int ib, logic nb);
    return (ib == 31) ? 64'h0 : fmt(eg[ib], nb);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state of outputs
    rd(31, 0, 0, 31, 0);
    chk("R4 reset zero A", rd_a_data, 0);
    chk("R4 reset zero B", rd_b_data, 0);
    chk("R7 reset no fault", 64'(sp_fault), 0);

    // R1 full sweep
    for (int i = 0; i < 31; i++) wr(i, 0, 0, pat(i));
    for (int l = 0; l < 4; l++) begin
      priv_lvl = 2'(l); sp_sel = 1;
      wr(31, 0, 1, 64'h1000 * 64'(l + 1));
    end
    for (int i = 0; i < 31; i++) begin
      rd(i, 0, 0, 30 - i, 0);
      chk($sformatf("R1 port A x%0d", i), rd_a_data, exp_a(i, 0, 0));
      chk($sformatf("R1 port B x%0d", 30 - i), rd_b_data, exp_b(30 - i, 0));
    end
    // R2 narrow reads
    for (int i = 0; i < 31; i++) begin
      rd(i, 1, 0, i, 1);
      chk($sformatf("R2 narrow A x%0d", i), rd_a_data, exp_a(i, 1, 0));
      chk($sformatf("R2 narrow B x%0d", i), rd_b_data, exp_b(i, 1));
    end
    // R3 narrow writes
    for (int i = 0; i < 31; i += 5) begin
      wr(i, 1, 0, ~pat(i));
      rd(i, 0, 0, i, 0);
      chk($sformatf("R3 narrow write x%0d", i), rd_a_data, {32'h0, ~pat(i)} & 64'hFFFF_FFFF);
    end
    // R4 discarded write to index 31
    priv_lvl = 2; sp_sel = 1;
    wr(31, 0, 0, 64'hDEAD_BEEF_0BAD_F00D);
    for (int i = 0; i < 31; i++) begin
      rd(i, 0, 0, i, 0);
      chk($sformatf("R4 gpr x%0d kept", i), rd_b_data, exp_b(i, 0));
    end
    for (int l = 0; l < 4; l++) begin
      priv_lvl = 2'(l);
      rd(31, 0, 1, 31, 0);
      chk($sformatf("R4 sp%0d kept", l), rd_a_data, es[l]);
      chk("R4 B zero", rd_b_data, 0);
      rd(31, 0, 0, 31, 0);
      chk("R4 A zero without sp", rd_a_data, 0);
    end
    // R5/R6 selection sweep
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++) begin
        priv_lvl = 2'(l); sp_sel = 1'(s);
        rd(31, 0, 1, 0, 0);
        chk($sformatf("R6 lvl%0d sel%0d", l, s), rd_a_data, es[(s == 1 && l != 0) ? l : 0]);
      end
    priv_lvl = 3; sp_sel = 0;
    wr(31, 0, 1, 64'h7770);
    priv_lvl = 3; sp_sel = 1;
    rd(31, 0, 1, 0, 0);
    chk("R5 lvl3 untouched by sel0 write", rd_a_data, 64'h4000);
    priv_lvl = 0; sp_sel = 1;
    rd(31, 0, 1, 0, 0);
    chk("R5 sp0 written", rd_a_data, 64'h7770);
    for (int i = 0; i < 31; i++) begin
      rd(i, 0, 0, i, 0);
      chk($sformatf("R5 gpr x%0d untouched", i), rd_b_data, exp_b(i, 0));
    end
    // R7 alignment
    priv_lvl = 2; sp_sel = 1; align_chk_en = 1;
    wr(31, 0, 1, 64'h2008);
    rd(31, 0, 1, 0, 0);
    chk("R7 misaligned fault", 64'(sp_fault), 1);
    chk("R7 value", rd_a_data, 64'h2008);
    sp_sel = 0;
    rd(31, 0, 1, 0, 0);
    chk("R7 aligned sp0 no fault", 64'(sp_fault), 0);
    sp_sel = 1;
    rd(31, 0, 0, 0, 0);
    chk("R7 no sp read no fault", 64'(sp_fault), 0);
    align_chk_en = 0;
    rd(31, 0, 1, 0, 0);
    chk("R7 disabled no fault", 64'(sp_fault), 0);
    align_chk_en = 1;
    // R8 link
    @(negedge clk); lnk_en = 1; lnk_addr = 64'hFFFF_0000_1234_5670;
    @(posedge clk); #1 lnk_en = 0; eg[30] = 64'hFFFF_0000_1234_5670;
    rd(30, 0, 0, 30, 0);
    chk("R8 link alone", rd_b_data, eg[30]);
    @(negedge clk);
    lnk_en = 1; lnk_addr = 64'hAAAA_5555_0000_1110;
    wr_en = 1; wr_idx = 30; wr_narrow = 0; wr_use_sp = 0; wr_data = 64'h1;
    @(posedge clk); #1 lnk_en = 0; wr_en = 0; eg[30] = 64'hAAAA_5555_0000_1110;
    rd(30, 0, 0, 30, 0);
    chk("R8 link beats write to x30", rd_a_data, eg[30]);
    @(negedge clk);
    lnk_en = 1; lnk_addr = 64'h0000_0000_C0DE_0004;
    wr_en = 1; wr_idx = 5; wr_data = 64'h5555_6666_7777_8888;
    @(posedge clk); #1 lnk_en = 0; wr_en = 0;
    eg[30] = 64'h0000_0000_C0DE_0004; eg[5] = 64'h5555_6666_7777_8888;
    rd(30, 0, 0, 5, 0);
    chk("R8 link x30 with other write", rd_a_data, eg[30]);
    chk("R8 other write x5 completes", rd_b_data, eg[5]);
    // R9 bypass
    @(negedge clk);
    wr_en = 1; wr_idx = 12; wr_narrow = 1; wr_use_sp = 0; wr_data = 64'hFEDC_BA98_7654_3210;
    rd_a_idx = 12; rd_a_narrow = 0; rd_a_use_sp = 0; rd_b_idx = 12; rd_b_narrow = 0;
    #5;
    chk("R9 bypass narrow A", rd_a_data, 64'h7654_3210);
    chk("R9 bypass narrow B", rd_b_data, 64'h7654_3210);
    @(posedge clk); #1 wr_en = 0; eg[12] = 64'h7654_3210;
    @(negedge clk);
    lnk_en = 1; lnk_addr = 64'h0123_4567_89AB_CDE0; rd_b_idx = 30;
    #5;
    chk("R9 bypass link", rd_b_data, 64'h0123_4567_89AB_CDE0);
    @(posedge clk); #1 lnk_en = 0; eg[30] = 64'h0123_4567_89AB_CDE0;
    priv_lvl = 1; sp_sel = 1;
    @(negedge clk);
    wr_en = 1; wr_idx = 31; wr_use_sp = 1; wr_narrow = 0; wr_data = 64'h3003;
    rd_a_idx = 31; rd_a_use_sp = 1;
    #5;
    chk("R9 bypass sp", rd_a_data, 64'h3003);
    chk("R9 R7 fault on bypassed sp", 64'(sp_fault), 1);
    @(posedge clk); #1 wr_en = 0; es[1] = 64'h3003;
    rd(31, 0, 1, 12, 0);
    chk("R9 sp committed", rd_a_data, 64'h3003);
    chk("R9 narrow committed", rd_b_data, eg[12]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule